// File: doc/BRIEF.md
# Multi-channel motor PWM modulator

The modulator is the time base for a motor-drive inverter. One free-running master counter sets the rhythm for six raw PWM channels. It advances once per prescaler tick and turns round at a programmable period value. Each channel compares the shared count against its own threshold, so all six waveforms stay locked to a single period. The counter runs in one of two modes. In sawtooth mode it climbs and then snaps back to zero. In triangle mode it climbs to the period value and then descends, which gives pulses that are symmetric about the period start.

Software programs the block through a small write-only register port. Settings that shape a period (thresholds, period value, prescale and mode) are held in staging registers. They move into the working set only when a new period begins, so no period ever runs with a mix of old and new settings. The run-enable bit takes effect at once.

Once per period the block emits a single-clock pulse for starting an ADC conversion in step with the waveform. It also emits a flag marking the last clock of each period. Dead-time, polarity and fault shutdown belong to a separate output stage that follows this block.

Top module: `mcpwm_modulator`

## Requirements
- R1: While reset is held, and after reset until the enable bit is written, every output is low and all registers read as zero with the enable bit off.
- R2: In sawtooth mode with period value P, the count steps 0,1,...,P and then returns to 0, so one period lasts P+1 count steps. A channel is high while the count is below its threshold.
- R3: In triangle mode with period value P>0, the count steps 0,1,...,P,P-1,...,1 and then returns to 0, so one period lasts 2P count steps. The same below-threshold rule applies on both slopes.
- R4: A prescale field value s (0 to 3) makes each count step last 2^s clocks.
- R5: Writes to the thresholds, the period, the prescale field and the mode bit take effect at the start of the next period. A write that lands during a period leaves that period unchanged.
- R6: `adc_trig` is high for exactly the first clock of every period. This includes the first period after enabling, which begins two clocks after the clock edge that captures the enable write.
- R7: `cyc_end` is high for exactly the last clock of every period, which is the clock just before `adc_trig`.
- R8: A threshold of 0 keeps its channel low for the whole period. A threshold at or above the period value keeps its channel high for the whole period.
- R9: Writing the enable bit to 0 drives all outputs low from the next clock and returns the counter and prescaler to zero. Enabling again starts a fresh period from count 0.
- R10: The register map is as follows. Addresses 0 to 5 hold the threshold for channel n = address. Address 6 holds the period value. Address 7 holds the prescale field in data bits [1:0]. Address 8 is the control register, with bit 0 = enable and bit 1 = triangle mode. Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 12 | Register write data |
| pwm_raw | output | 6 | Raw PWM level per channel; bit n is channel n |
| adc_trig | output | 1 | One-clock pulse at the first clock of each period |
| cyc_end | output | 1 | One-clock flag at the last clock of each period |

## Verification
The hardest situation to reach from the ports is a settings change that lands in the middle of a running period, and above all a switch from sawtooth to triangle mode. The old waveform must run to its last clock, and the new mode, period and prescale must all take hold on the same edge. The stimulus reaches this by computing the whole expected output stream in advance: one period with the old settings followed by periods with the new ones. It then issues the writes at known clocks inside the first period while the monitor checks every clock. Writes to unused addresses are placed inside such a stream, so that any aliasing onto a real register would show up as a broken waveform.

// File: rtl/mcpwm_pkg.sv
`timescale 1ns/1ps
// Shared sizes and types for the motor PWM modulator.
package mcpwm_pkg;
    localparam int CNT_W_DEF  = 12;  // master counter width
    localparam int N_CH_DEF   = 6;   // number of compare channels
    localparam int SEL_W_DEF  = 2;   // prescale select width (divide 1..2^(2^SEL_W-1))
    localparam int ADDR_W_DEF = 4;   // register address width

    // Counter shape: sawtooth or triangle.
    typedef enum logic {
        ALIGN_EDGE   = 1'b0,
        ALIGN_CENTER = 1'b1
    } align_e;
endpackage

// File: rtl/mcpwm_regs.sv
`timescale 1ns/1ps
// Register file of the modulator.
// What: staging copies of thresholds, period, prescale and mode, loaded from
// the write port; working copies taken from the staging set on `load`.
// The enable bit is not staged and acts at once.
// Assumes: `load` is asserted by the counter while idle and on the last
// clock of each period; CNT_W >= 2.
module mcpwm_regs
    import mcpwm_pkg::*;
#(
    parameter int CNT_W  = CNT_W_DEF,
    parameter int N_CH   = N_CH_DEF,
    parameter int SEL_W  = SEL_W_DEF,
    parameter int ADDR_W = ADDR_W_DEF
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [CNT_W-1:0]               wr_data,
    input  logic                           load,
    output logic                           en_q,
    output align_e                         mode_q,
    output logic [CNT_W-1:0]               per_q,
    output logic [SEL_W-1:0]               sel_q,
    output logic [N_CH-1:0][CNT_W-1:0]     cmp_q
);
    localparam logic [ADDR_W-1:0] ADR_PER = ADDR_W'(N_CH);
    localparam logic [ADDR_W-1:0] ADR_PRE = ADDR_W'(N_CH + 1);
    localparam logic [ADDR_W-1:0] ADR_CTL = ADDR_W'(N_CH + 2);

    logic [CNT_W-1:0] cmp_sh [N_CH];
    logic [CNT_W-1:0] per_sh;
    logic [SEL_W-1:0] sel_sh;
    align_e           mode_sh;

    // One staging threshold per channel, decoded from its own address.
    for (genvar ch = 0; ch < N_CH; ch++) begin : g_cmp_sh
        always_ff @(posedge clk) begin
            if (!rst_n)
                cmp_sh[ch] <= '0;
            else if (wr_en && (wr_addr == ADDR_W'(ch)))
                cmp_sh[ch] <= wr_data;
        end
    end

    // Staging period, prescale, mode and the immediate enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_sh  <= '0;
            sel_sh  <= '0;
            mode_sh <= ALIGN_EDGE;
            en_q    <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == ADR_PER) per_sh <= wr_data;
            if (wr_addr == ADR_PRE) sel_sh <= wr_data[SEL_W-1:0];
            if (wr_addr == ADR_CTL) begin
                en_q    <= wr_data[0];
                mode_sh <= wr_data[1] ? ALIGN_CENTER : ALIGN_EDGE;
            end
        end
    end

    // Working set: copied from staging only at a period start or while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q  <= '0;
            sel_q  <= '0;
            mode_q <= ALIGN_EDGE;
            cmp_q  <= '0;
        end else if (load) begin
            per_q  <= per_sh;
            sel_q  <= sel_sh;
            mode_q <= mode_sh;
            for (int ch = 0; ch < N_CH; ch++) cmp_q[ch] <= cmp_sh[ch];
        end
    end

    // R5: working settings never move between loads.
    p_hold_between_loads_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(cmp_q) && $stable(per_q) && $stable(sel_q) && $stable(mode_q)));
endmodule

// File: rtl/mcpwm_prescaler.sv
`timescale 1ns/1ps
// Clock prescaler for the master counter.
// What: emits `tick` once every 2^sel clocks while `run` is high.
// Assumes: sel only changes on a tick or while not running, so the
// divider phase restarts cleanly at every period start.
module mcpwm_prescaler #(
    parameter int SEL_W = mcpwm_pkg::SEL_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PRE_W = (1 << SEL_W) - 1;

    logic [PRE_W-1:0] pre;
    logic [PRE_W-1:0] lim;

    // Terminal value 2^sel - 1 as a thermometer mask.
    always_comb begin
        for (int k = 0; k < PRE_W; k++) lim[k] = (k < int'(sel));
    end

    assign tick = run && (pre == lim);

    // Divider phase: cleared when idle and after every tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            pre <= '0;
        else if (tick)
            pre <= '0;
        else
            pre <= pre + PRE_W'(1);
    end

    // R4: the phase never passes the selected terminal value.
    p_phase_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (pre <= lim));
endmodule

// File: rtl/mcpwm_counter.sv
`timescale 1ns/1ps
// Master counter of the modulator.
// What: counts on prescaler ticks in sawtooth or triangle shape, marks the
// last clock of each period, requests the working-set load and produces
// the ADC start pulse on the first clock of every period.
// Assumes: per and center come from the working set, which only changes
// when `load` is high; the first clock after enabling is spent idle.
module mcpwm_counter
    import mcpwm_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  align_e           center,
    input  logic [CNT_W-1:0] per,
    input  logic             tick,
    output logic             counting,
    output logic [CNT_W-1:0] cnt,
    output logic             load,
    output logic             cyc_end,
    output logic             adc_trig
);
    logic             run_q;
    logic             dn_q;
    logic             adc_q;
    logic [CNT_W-1:0] nxt;
    logic             nxt_dn;
    logic             step;

    // Next count and direction for either counter shape.
    always_comb begin
        nxt    = cnt;
        nxt_dn = dn_q;
        if (center == ALIGN_EDGE) begin
            nxt_dn = 1'b0;
            nxt    = (cnt >= per) ? '0 : cnt + CNT_W'(1);
        end else if (per == '0) begin
            nxt_dn = 1'b0;
            nxt    = '0;
        end else if (!dn_q && (cnt < per)) begin
            nxt    = cnt + CNT_W'(1);
        end else begin
            nxt    = cnt - CNT_W'(1);
            nxt_dn = (cnt != CNT_W'(1));
        end
    end

    assign counting = run_q && en;
    assign step     = counting && tick;
    assign cyc_end  = step && (nxt == '0);
    assign load     = !run_q || cyc_end;
    assign adc_trig = adc_q && en;

    // Count state, run flag and the registered period-start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            run_q <= 1'b0;
            cnt   <= '0;
            dn_q  <= 1'b0;
            adc_q <= 1'b0;
        end else begin
            run_q <= 1'b1;
            adc_q <= !run_q || cyc_end;
            if (step) begin
                cnt  <= nxt;
                dn_q <= nxt_dn;
            end
        end
    end

    // R2: the count never exceeds the working period value.
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= per);
    // R3: the falling slope never sits at zero.
    p_down_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dn_q |-> (cnt != '0));
    // R6: the ADC pulse coincides with count zero.
    p_adc_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        adc_trig |-> (cnt == '0));
    // R7: the period-end flag is followed by the ADC pulse unless disabled.
    p_end_then_adc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_end |=> (adc_trig || !en));
endmodule

// File: rtl/mcpwm_compare.sv
`timescale 1ns/1ps
// Compare bank of the modulator.
// What: one comparator per channel against the shared count; threshold 0
// forces low, threshold at or above the period forces high.
// Assumes: cnt, per and cmp are registered; outputs are combinational and
// are registered by the output stage that follows.
module mcpwm_compare #(
    parameter int CNT_W = mcpwm_pkg::CNT_W_DEF,
    parameter int N_CH  = mcpwm_pkg::N_CH_DEF
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       active,
    input  logic [CNT_W-1:0]           cnt,
    input  logic [CNT_W-1:0]           per,
    input  logic [N_CH-1:0][CNT_W-1:0] cmp,
    output logic [N_CH-1:0]            pwm
);
    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        // Channel level from the shared count.
        assign pwm[ch] = active && (cmp[ch] != '0) &&
                         ((cmp[ch] >= per) || (cnt < cmp[ch]));

        // R8: a zero threshold never raises its channel.
        p_zero_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (cmp[ch] == '0) |-> !pwm[ch]);
    end
endmodule

// File: rtl/mcpwm_modulator.sv
`timescale 1ns/1ps
// Multi-channel motor PWM modulator, top level.
// What: register port, prescaler, master counter and compare bank wired
// into one time base with six raw outputs, an ADC start pulse and a
// period-end flag.
// Assumes: synchronous active-low reset; outputs feed a registered
// dead-time and protection stage.
module mcpwm_modulator
    import mcpwm_pkg::*;
#(
    parameter int CNT_W  = CNT_W_DEF,
    parameter int N_CH   = N_CH_DEF,
    parameter int SEL_W  = SEL_W_DEF,
    parameter int ADDR_W = ADDR_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [N_CH-1:0]   pwm_raw,
    output logic              adc_trig,
    output logic              cyc_end
);
    logic                       en_q;
    align_e                     mode_q;
    logic [CNT_W-1:0]           per_q;
    logic [SEL_W-1:0]           sel_q;
    logic [N_CH-1:0][CNT_W-1:0] cmp_q;
    logic                       load;
    logic                       tick;
    logic                       counting;
    logic [CNT_W-1:0]           cnt;

    mcpwm_regs #(.CNT_W(CNT_W), .N_CH(N_CH), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .load(load), .en_q(en_q), .mode_q(mode_q), .per_q(per_q), .sel_q(sel_q),
        .cmp_q(cmp_q)
    );

    mcpwm_prescaler #(.SEL_W(SEL_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(counting), .sel(sel_q), .tick(tick)
    );

    mcpwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(en_q), .center(mode_q), .per(per_q),
        .tick(tick), .counting(counting), .cnt(cnt), .load(load),
        .cyc_end(cyc_end), .adc_trig(adc_trig)
    );

    mcpwm_compare #(.CNT_W(CNT_W), .N_CH(N_CH)) u_cmp (
        .clk(clk), .rst_n(rst_n), .active(counting), .cnt(cnt), .per(per_q),
        .cmp(cmp_q), .pwm(pwm_raw)
    );

    // R9: with the enable bit off every output stays quiet.
    p_quiet_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> ((pwm_raw == '0) && !adc_trig && !cyc_end));
endmodule

// File: tb/mcpwm_modulator_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks push the expected per-clock output stream,
// a monitor pops one item per clock and compares it with the ports.
module mcpwm_modulator_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [11:0] wr_data = '0;
    logic [5:0]  pwm_raw;
    logic        adc_trig;
    logic        cyc_end;

    int checks = 0;
    int failures = 0;
    int cmp_cfg [6];

    typedef struct packed {
        logic [5:0] pwm;
        logic       adc;
        logic       ce;
    } exp_t;

    exp_t  exp_q [$];
    string tag_q [$];

    always #10 clk = ~clk;

    mcpwm_modulator u_mcpwm_modulator (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pwm_raw(pwm_raw), .adc_trig(adc_trig), .cyc_end(cyc_end)
    );

    task automatic chk(input bit ok, input string req, input string act, input string expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%s expected=%s", req, act, expv);
        end
    endtask

    function automatic bit level(input int c, input int p, input int v);
        return (c != 0) && ((c >= p) || (v < c));
    endfunction

    // Expected stream for nper periods; fields are {pwm[5:0], adc_trig, cyc_end}.
    task automatic push_periods(input int per, input bit ctr, input int sel,
                                input int nper, input string tag);
        int div;
        int vals [$];
        exp_t e;
        div = 1 << sel;
        #1;
        for (int k = 0; k < nper; k++) begin
            vals.delete();
            if (!ctr) begin
                for (int v = 0; v <= per; v++) vals.push_back(v);
            end else if (per == 0) begin
                vals.push_back(0);
            end else begin
                for (int v = 0; v <= per; v++) vals.push_back(v);
                for (int v = per - 1; v >= 1; v--) vals.push_back(v);
            end
            for (int j = 0; j < vals.size(); j++) begin
                for (int d = 0; d < div; d++) begin
                    for (int ch = 0; ch < 6; ch++) e.pwm[ch] = level(cmp_cfg[ch], per, vals[j]);
                    e.adc = (j == 0) && (d == 0);
                    e.ce  = (j == vals.size() - 1) && (d == div - 1);
                    exp_q.push_back(e);
                    tag_q.push_back(tag);
                end
            end
        end
    endtask

    task automatic write_reg(input int a, input int d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 4'(a);
        wr_data = 12'(d);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic chk_quiet(input string req);
        chk({pwm_raw, adc_trig, cyc_end} == 8'h00, req,
            $sformatf("%b", {pwm_raw, adc_trig, cyc_end}), "00000000");
    endtask

    // Monitor: one expected item per clock, sampled at the falling edge.
    initial begin
        exp_t  e;
        string t;
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({pwm_raw, adc_trig, cyc_end} == e, t,
                    $sformatf("%b", {pwm_raw, adc_trig, cyc_end}), $sformatf("%b", e));
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL all: watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        cmp_cfg = '{0, 1, 3, 5, 6, 2};
        repeat (5) @(negedge clk);
        chk_quiet("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_quiet("R1 after reset");

        // Sawtooth, P=5, divide 1; unused addresses written mid-stream (R10).
        for (int ch = 0; ch < 6; ch++) write_reg(ch, cmp_cfg[ch]);
        write_reg(6, 5);
        write_reg(7, 0);
        chk_quiet("R1 enable still off");
        write_reg(8, 1);
        push_periods(5, 1'b0, 0, 4, "R2 R6 R7 R8 R10");
        for (int a = 9; a < 16; a++) write_reg(a, 0);
        drain();

        // Mid-period changes of threshold, period and prescale (R5, R4).
        push_periods(5, 1'b0, 0, 1, "R5 old period kept");
        cmp_cfg[1] = 4;
        push_periods(7, 1'b0, 1, 2, "R4 R5 new settings");
        write_reg(1, 4);
        write_reg(6, 7);
        write_reg(7, 1);
        drain();

        // Mode switch to triangle mid-period (R3, R5).
        push_periods(7, 1'b0, 1, 1, "R5 mode held");
        push_periods(7, 1'b1, 1, 2, "R3 R5 triangle");
        write_reg(8, 3);
        drain();

        // Triangle with divide 8, small period, threshold 1 (R3, R4, R8).
        push_periods(7, 1'b1, 1, 1, "R3 old triangle");
        cmp_cfg[2] = 1;
        push_periods(2, 1'b1, 3, 2, "R3 R4 R8 divide8");
        write_reg(2, 1);
        write_reg(6, 2);
        write_reg(7, 3);
        drain();

        // Disable, reprogram while off, then restart (R9, R6).
        write_reg(8, 0);
        chk_quiet("R9 off next clock");
        repeat (3) begin
            @(negedge clk);
            chk_quiet("R9 stays off");
        end
        cmp_cfg = '{2, 0, 3, 1, 7, 4};
        for (int ch = 0; ch < 6; ch++) write_reg(ch, cmp_cfg[ch]);
        write_reg(6, 3);
        write_reg(7, 0);
        chk_quiet("R9 writes while off");
        write_reg(8, 1);
        push_periods(3, 1'b0, 0, 3, "R2 R6 R9 restart");
        drain();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule